// File: doc/BRIEF.md
# Speculative Line Lock Tracker

This block holds the tag-side state of a set-associative L1 data cache that keeps unverified stores away from the next memory level. Every line has a valid, a dirty and a speculative bit. A store hit marks its line speculative, and a speculative line is locked. It cannot be chosen as a victim and it cannot be written back. The next level therefore only ever receives data that has passed a fingerprint check. Before a store lands on a dirty line whose data is already verified, the block asks for that verified copy to be written back, so a good copy exists for recovery.

When a replacement finds every way of its set locked, the block asks for a fingerprint comparison and holds the fill. A matching fingerprint starts a sweep that clears the speculative bits one set per cycle. A mismatch starts a sweep that invalidates only the speculative lines, one set per cycle, which rolls memory back to the last verified state. While a sweep runs, the block is busy and refuses stores and fills. When a line moves to another cache, its speculative bit goes with it. A fill takes that bit as an input, and a read port returns the state of any line.

Top module: `spec_lock_tracker`

## Requirements
- R1: After reset every line is invalid, clean and non-speculative, the round-robin pointer of every set is 0, and busy is low.
- R2: A store hit (wr_req) on a valid line, while not busy, is accepted (wr_ok high in that cycle) and sets the line's dirty and speculative bits. A store to an invalid line, or any store while busy, is ignored.
- R3: An accepted store to a dirty, non-speculative line raises wb_req in the same cycle, with wb_set/wb_way naming that line.
- R4: A speculative line is never the target of wb_req and is never chosen as victim_way when fill_grant is high.
- R5: Victim choice takes the lowest-numbered invalid way of the set if there is one. Otherwise it scans the valid non-speculative ways circularly, starting at the set's pointer. After each granted fill, that set's pointer becomes (victim_way + 1) mod WAYS.
- R6: A granted fill (fill_grant high) makes the victim valid and sets its speculative and dirty bits both equal to fill_spec_in. The read port (rd_valid, rd_dirty, rd_spec) shows the stored bits of line rd_set/rd_way.
- R7: A granted fill whose victim is valid and dirty raises wb_req for that victim in the same cycle.
- R8: A fill request while not busy, to a set where every way is valid and speculative, raises fp_req and gets no grant. The fill waits for as long as the request is held.
- R9: A pulse on fp_match or fp_mismatch while not busy makes busy high from the next cycle for exactly SETS cycles. In each busy cycle one set is processed, starting at set 0 in ascending order. If both pulses come together, fp_mismatch wins. A match sweep clears speculative bits and leaves valid and dirty bits unchanged.
- R10: A mismatch sweep clears valid, dirty and speculative on every speculative line and leaves other lines unchanged. During each of its cycles, inv_valid is high, inv_set is the set being processed, and inv_mask has a 1 for each way being invalidated.
- R11: While busy, wr_ok, fill_grant, fp_req and wb_req stay low, and further fp_match/fp_mismatch pulses are ignored.
- R12: When wr_req and fill_req are both high in one cycle, the store is handled and fill_grant stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Store hit request |
| wr_set | input | log2(SETS) | Set of the store |
| wr_way | input | log2(WAYS) | Way of the store |
| wr_ok | output | 1 | Store accepted this cycle |
| fill_req | input | 1 | Replacement/fill request |
| fill_set | input | log2(SETS) | Set to fill |
| fill_spec_in | input | 1 | Speculative bit carried with the incoming line |
| fill_grant | output | 1 | Fill performed into victim_way this cycle |
| victim_way | output | log2(WAYS) | Chosen victim way |
| fp_req | output | 1 | Fingerprint comparison requested (set fully locked) |
| fp_match | input | 1 | Fingerprint match pulse |
| fp_mismatch | input | 1 | Fingerprint mismatch pulse |
| busy | output | 1 | Sweep in progress |
| wb_req | output | 1 | Write back a verified line to L2 |
| wb_set | output | log2(SETS) | Set of the writeback line |
| wb_way | output | log2(WAYS) | Way of the writeback line |
| inv_valid | output | 1 | Rollback sweep is invalidating inv_set |
| inv_set | output | log2(SETS) | Set being swept |
| inv_mask | output | WAYS | Ways invalidated in inv_set |
| rd_set | input | log2(SETS) | Read port set |
| rd_way | input | log2(WAYS) | Read port way |
| rd_valid | output | 1 | Valid bit of the read line |
| rd_dirty | output | 1 | Dirty bit of the read line |
| rd_spec | output | 1 | Speculative bit of the read line |

## Verification
The cycle-by-cycle assertions cover the lock itself: no writeback and no grant ever touches a speculative line, a locking request never comes with a grant, and a sweep starts only after a fingerprint pulse and never ends while any speculative bit remains set. Other behaviour is shown by the bench's scenarios, which compare against a reference model in the bench. These cover the round-robin order and the preference for invalid ways, the writeback of a verified copy before a store, a held fill that waits through a full match sweep before it is granted, and a rollback that removes only the speculative lines.

// File: rtl/spec_lock_pkg.sv
package spec_lock_pkg;
   typedef enum logic {
      SWEEP_CLEAN    = 1'b0,
      SWEEP_ROLLBACK = 1'b1
   } sweep_kind_e;
endpackage

// File: rtl/spec_lock_victim.sv
module spec_lock_victim #(
   parameter int WAYS = 4,
   localparam int WB = $clog2(WAYS)
) (
   input  logic [WAYS-1:0] line_vld,
   input  logic [WAYS-1:0] line_spc,
   input  logic [WB-1:0]   rr_ptr,
   output logic            found,
   output logic [WB-1:0]   way
);
   logic [WAYS-1:0] empty_w;
   logic [WAYS-1:0] evictable_w;

   genvar g;
   generate
      for (g = 0; g < WAYS; g++) begin : g_way
         assign empty_w[g]     = ~line_vld[g];
         assign evictable_w[g] = line_vld[g] & ~line_spc[g];
      end
   endgenerate

   always_comb begin
      logic          hit;
      logic [WB-1:0] idx;
      hit   = 1'b0;
      way   = '0;
      idx   = '0;
      found = |(empty_w | evictable_w);
      for (int k = 0; k < WAYS; k++) begin
         if (!hit && empty_w[k]) begin
            way = WB'(k);
            hit = 1'b1;
         end
      end
      for (int k = 0; k < WAYS; k++) begin
         idx = rr_ptr + WB'(k);
         if (!hit && evictable_w[idx]) begin
            way = idx;
            hit = 1'b1;
         end
      end
   end
endmodule

// File: rtl/spec_lock_sweep.sv
module spec_lock_sweep
   import spec_lock_pkg::*;
#(
   parameter int SETS = 8,
   localparam int SB = $clog2(SETS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fp_match,
   input  logic          fp_mismatch,
   output logic          busy,
   output logic [SB-1:0] cur_set,
   output sweep_kind_e   kind
);
   localparam logic [SB-1:0] LAST_SET = SB'(SETS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cur_set <= '0;
         kind    <= SWEEP_CLEAN;
      end else if (!busy) begin
         if (fp_match || fp_mismatch) begin
            busy    <= 1'b1;
            cur_set <= '0;
            kind    <= fp_mismatch ? SWEEP_ROLLBACK : SWEEP_CLEAN;
         end
      end else if (cur_set == LAST_SET) begin
         busy <= 1'b0;
      end else begin
         cur_set <= cur_set + SB'(1);
      end
   end

   // R9: a sweep only begins after a fingerprint result
   assert_sweep_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(fp_match || fp_mismatch));

   // R9: every sweep starts at set 0
   assert_sweep_first_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> cur_set == '0);
endmodule

// File: rtl/spec_lock_tracker.sv
module spec_lock_tracker
   import spec_lock_pkg::*;
#(
   parameter int SETS = 8,
   parameter int WAYS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_req,
   input  logic [$clog2(SETS)-1:0]  wr_set,
   input  logic [$clog2(WAYS)-1:0]  wr_way,
   output logic                     wr_ok,
   input  logic                     fill_req,
   input  logic [$clog2(SETS)-1:0]  fill_set,
   input  logic                     fill_spec_in,
   output logic                     fill_grant,
   output logic [$clog2(WAYS)-1:0]  victim_way,
   output logic                     fp_req,
   input  logic                     fp_match,
   input  logic                     fp_mismatch,
   output logic                     busy,
   output logic                     wb_req,
   output logic [$clog2(SETS)-1:0]  wb_set,
   output logic [$clog2(WAYS)-1:0]  wb_way,
   output logic                     inv_valid,
   output logic [$clog2(SETS)-1:0]  inv_set,
   output logic [WAYS-1:0]          inv_mask,
   input  logic [$clog2(SETS)-1:0]  rd_set,
   input  logic [$clog2(WAYS)-1:0]  rd_way,
   output logic                     rd_valid,
   output logic                     rd_dirty,
   output logic                     rd_spec
);
   localparam int SB = $clog2(SETS);
   localparam int WB = $clog2(WAYS);
   localparam logic [WB-1:0] WAY_STEP = WB'(1);

   generate
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("SETS must be a power of two of at least 2");
      end
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("WAYS must be a power of two of at least 2");
      end
   endgenerate

   logic [WAYS-1:0] vld_q [SETS];
   logic [WAYS-1:0] drt_q [SETS];
   logic [WAYS-1:0] spc_q [SETS];
   logic [WB-1:0]   rr_q  [SETS];

   logic          pick_found;
   logic [SB-1:0] sweep_set;
   sweep_kind_e   sweep_kind;
   logic          all_locked;
   logic          wr_wb;
   logic          ev_wb;
   logic          any_spec;

   spec_lock_victim #(.WAYS(WAYS)) u_pick (
      .line_vld (vld_q[fill_set]),
      .line_spc (spc_q[fill_set]),
      .rr_ptr   (rr_q[fill_set]),
      .found    (pick_found),
      .way      (victim_way)
   );

   spec_lock_sweep #(.SETS(SETS)) u_sweep (
      .clk         (clk),
      .rst_n       (rst_n),
      .fp_match    (fp_match),
      .fp_mismatch (fp_mismatch),
      .busy        (busy),
      .cur_set     (sweep_set),
      .kind        (sweep_kind)
   );

   assign all_locked = &(vld_q[fill_set] & spc_q[fill_set]);
   assign wr_ok      = wr_req && !busy && vld_q[wr_set][wr_way];
   assign fill_grant = fill_req && !busy && !wr_req && pick_found;
   assign fp_req     = fill_req && !busy && all_locked;

   assign wr_wb  = wr_ok && drt_q[wr_set][wr_way] && !spc_q[wr_set][wr_way];
   assign ev_wb  = fill_grant && vld_q[fill_set][victim_way] && drt_q[fill_set][victim_way];
   assign wb_req = wr_wb || ev_wb;
   assign wb_set = wr_wb ? wr_set : fill_set;
   assign wb_way = wr_wb ? wr_way : victim_way;

   assign inv_valid = busy && (sweep_kind == SWEEP_ROLLBACK);
   assign inv_set   = sweep_set;
   assign inv_mask  = inv_valid ? (vld_q[sweep_set] & spc_q[sweep_set]) : '0;

   assign rd_valid = vld_q[rd_set][rd_way];
   assign rd_dirty = drt_q[rd_set][rd_way];
   assign rd_spec  = spc_q[rd_set][rd_way];

   always_comb begin
      any_spec = 1'b0;
      for (int s = 0; s < SETS; s++) begin
         any_spec = any_spec | (|spc_q[s]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            drt_q[s] <= '0;
            spc_q[s] <= '0;
            rr_q[s]  <= '0;
         end
      end else if (busy) begin
         if (sweep_kind == SWEEP_ROLLBACK) begin
            vld_q[sweep_set] <= vld_q[sweep_set] & ~spc_q[sweep_set];
            drt_q[sweep_set] <= drt_q[sweep_set] & ~spc_q[sweep_set];
         end
         spc_q[sweep_set] <= '0;
      end else if (wr_ok) begin
         spc_q[wr_set][wr_way] <= 1'b1;
         drt_q[wr_set][wr_way] <= 1'b1;
      end else if (fill_grant) begin
         vld_q[fill_set][victim_way] <= 1'b1;
         drt_q[fill_set][victim_way] <= fill_spec_in;
         spc_q[fill_set][victim_way] <= fill_spec_in;
         rr_q[fill_set]              <= victim_way + WAY_STEP;
      end
   end

   // R4: locked lines never leave toward L2
   assert_no_locked_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> !spc_q[wb_set][wb_way]);

   // R4: a granted victim is never speculative
   assert_victim_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_grant |-> !(vld_q[fill_set][victim_way] && spc_q[fill_set][victim_way]));

   // R8: a fully locked set cannot be granted
   assert_locked_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fp_req |-> !fill_grant);

   // R9 / R10: once a sweep has finished no speculative bit is left
   assert_sweep_leaves_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !any_spec);

   // R11: no traffic while sweeping
   assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(wr_ok || fill_grant || fp_req || wb_req));
endmodule

// File: tb/spec_lock_tracker_test.sv
module spec_lock_tracker_test;
   localparam int SETS = 8;
   localparam int WAYS = 4;
   localparam int SB = $clog2(SETS);
   localparam int WB = $clog2(WAYS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_req = 1'b0, fill_req = 1'b0, fill_spec_in = 1'b0;
   logic fp_match = 1'b0, fp_mismatch = 1'b0;
   logic [SB-1:0] wr_set = '0, fill_set = '0, rd_set = '0;
   logic [WB-1:0] wr_way = '0, rd_way = '0;
   logic wr_ok, fill_grant, fp_req, busy, wb_req, inv_valid;
   logic rd_valid, rd_dirty, rd_spec;
   logic [WB-1:0] victim_way, wb_way;
   logic [SB-1:0] wb_set, inv_set;
   logic [WAYS-1:0] inv_mask;

   always #5 clk = ~clk;

   spec_lock_tracker #(.SETS(SETS), .WAYS(WAYS)) uut (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_req), .wr_set(wr_set), .wr_way(wr_way), .wr_ok(wr_ok),
      .fill_req(fill_req), .fill_set(fill_set), .fill_spec_in(fill_spec_in),
      .fill_grant(fill_grant), .victim_way(victim_way), .fp_req(fp_req),
      .fp_match(fp_match), .fp_mismatch(fp_mismatch), .busy(busy),
      .wb_req(wb_req), .wb_set(wb_set), .wb_way(wb_way),
      .inv_valid(inv_valid), .inv_set(inv_set), .inv_mask(inv_mask),
      .rd_set(rd_set), .rd_way(rd_way),
      .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_spec(rd_spec)
   );

   int checks = 0;
   int failures = 0;

   // reference model
   bit mv [SETS][WAYS];
   bit md [SETS][WAYS];
   bit ms [SETS][WAYS];
   int mptr [SETS];
   bit mbusy = 0;
   bit mroll = 0;
   int mcnt = 0;

   // expected values for the current cycle
   bit e_wr_ok, e_grant, e_fp, e_wb, e_inv;
   int e_victim, e_wb_set, e_wb_way;
   int e_mask;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d time=%0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int pick_victim(int s);
      for (int w = 0; w < WAYS; w++) if (!mv[s][w]) return w;
      for (int k = 0; k < WAYS; k++) begin
         int idx;
         idx = (mptr[s] + k) % WAYS;
         if (mv[s][idx] && !ms[s][idx]) return idx;
      end
      return -1;
   endfunction

   function automatic bit set_locked(int s);
      for (int w = 0; w < WAYS; w++) if (!(mv[s][w] && ms[s][w])) return 0;
      return 1;
   endfunction

   task automatic calc_expect();
      int v;
      v = pick_victim(int'(fill_set));
      e_victim = v;
      e_wr_ok  = wr_req && !mbusy && mv[wr_set][wr_way];
      e_grant  = fill_req && !mbusy && !wr_req && (v >= 0);
      e_fp     = fill_req && !mbusy && set_locked(int'(fill_set));
      e_wb = 0; e_wb_set = 0; e_wb_way = 0;
      if (e_wr_ok && md[wr_set][wr_way] && !ms[wr_set][wr_way]) begin
         e_wb = 1; e_wb_set = int'(wr_set); e_wb_way = int'(wr_way);
      end else if (e_grant && mv[fill_set][v] && md[fill_set][v]) begin
         e_wb = 1; e_wb_set = int'(fill_set); e_wb_way = v;
      end
      e_inv = mbusy && mroll;
      e_mask = 0;
      if (e_inv)
         for (int w = 0; w < WAYS; w++)
            if (mv[mcnt][w] && ms[mcnt][w]) e_mask |= (1 << w);
   endtask

   task automatic update_model();
      if (mbusy) begin
         for (int w = 0; w < WAYS; w++) begin
            if (mroll && ms[mcnt][w]) begin
               mv[mcnt][w] = 0; md[mcnt][w] = 0;
            end
            ms[mcnt][w] = 0;
         end
         if (mcnt == SETS - 1) mbusy = 0; else mcnt++;
      end else begin
         if (fp_match || fp_mismatch) begin
            mbusy = 1; mcnt = 0; mroll = fp_mismatch;
         end
         if (e_wr_ok) begin
            ms[wr_set][wr_way] = 1; md[wr_set][wr_way] = 1;
         end else if (e_grant) begin
            mv[fill_set][e_victim] = 1;
            md[fill_set][e_victim] = fill_spec_in;
            ms[fill_set][e_victim] = fill_spec_in;
            mptr[fill_set] = (e_victim + 1) % WAYS;
         end
      end
   endtask

   // one clock: check all outputs before the edge, then advance model
   task automatic step();
      #1;
      calc_expect();
      chk("R2", "wr_ok", int'(wr_ok), int'(e_wr_ok));
      chk("R12", "fill_grant", int'(fill_grant), int'(e_grant));
      if (e_grant) chk("R5", "victim_way", int'(victim_way), e_victim);
      chk("R8", "fp_req", int'(fp_req), int'(e_fp));
      chk("R9", "busy", int'(busy), int'(mbusy));
      chk("R7", "wb_req", int'(wb_req), int'(e_wb));
      if (e_wb) begin
         chk("R3", "wb_set", int'(wb_set), e_wb_set);
         chk("R3", "wb_way", int'(wb_way), e_wb_way);
      end
      chk("R10", "inv_valid", int'(inv_valid), int'(e_inv));
      if (e_inv) begin
         chk("R10", "inv_set", int'(inv_set), mcnt);
         chk("R10", "inv_mask", int'(inv_mask), e_mask);
      end
      chk("R6", "rd_valid", int'(rd_valid), int'(mv[rd_set][rd_way]));
      chk("R6", "rd_dirty", int'(rd_dirty), int'(md[rd_set][rd_way]));
      chk("R6", "rd_spec", int'(rd_spec), int'(ms[rd_set][rd_way]));
      @(posedge clk);
      update_model();
      @(negedge clk);
   endtask

   task automatic idle();
      wr_req = 0; fill_req = 0; fp_match = 0; fp_mismatch = 0; fill_spec_in = 0;
   endtask

   task automatic read_line(int s, int w, string req, int ev, int ed, int es);
      rd_set = SB'(s); rd_way = WB'(w);
      #1;
      chk(req, "rd_valid", int'(rd_valid), ev);
      chk(req, "rd_dirty", int'(rd_dirty), ed);
      chk(req, "rd_spec", int'(rd_spec), es);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4242));
      for (int s = 0; s < SETS; s++) begin
         mptr[s] = 0;
         for (int w = 0; w < WAYS; w++) begin mv[s][w] = 0; md[s][w] = 0; ms[s][w] = 0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1", "busy", int'(busy), 0);
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++)
            read_line(s, w, "R1", 0, 0, 0);

      // R5: fill an empty set with verified lines: lowest invalid way each time
      idle(); fill_set = 1; fill_req = 1;
      for (int i = 0; i < WAYS; i++) begin
         #1 chk("R5", "victim_empty_way", int'(victim_way), i);
         step();
      end
      idle();
      // R2: store to an invalid line is ignored
      wr_req = 1; wr_set = 2; wr_way = 0; step(); idle();
      read_line(2, 0, "R2", 0, 0, 0);
      // R2: lock all ways of set 1
      for (int w = 0; w < WAYS; w++) begin
         wr_req = 1; wr_set = 1; wr_way = WB'(w); step();
      end
      idle();
      read_line(1, 3, "R2", 1, 1, 1);
      // R8: fully locked set requests comparison and waits
      fill_req = 1; fill_set = 1;
      for (int i = 0; i < 3; i++) begin
         #1 chk("R8", "fp_req_locked", int'(fp_req), 1);
         chk("R8", "no_grant_locked", int'(fill_grant), 0);
         step();
      end
      // R9: match sweep while fill held
      fp_match = 1; step(); fp_match = 0;
      for (int i = 0; i < SETS; i++) begin
         #1 chk("R9", "busy_during_sweep", int'(busy), 1);
         chk("R11", "grant_blocked", int'(fill_grant), 0);
         if (i == 2) fp_mismatch = 1;   // R11: ignored while busy
         step();
         fp_mismatch = 0;
      end
      // R7: after match, lines are dirty verified; grant evicts with writeback
      #1 chk("R9", "busy_after_sweep", int'(busy), 0);
      chk("R7", "grant_after_match", int'(fill_grant), 1);
      chk("R7", "wb_on_evict", int'(wb_req), 1);
      step(); idle();
      read_line(1, 1, "R9", 1, 1, 0);
      // R3: store to dirty verified line
      wr_req = 1; wr_set = 1; wr_way = 1;
      #1 chk("R3", "wb_before_store", int'(wb_req), 1);
      chk("R3", "wb_way_store", int'(wb_way), 1);
      step(); idle();
      // R12: store and fill together
      wr_req = 1; wr_set = 1; wr_way = 2; fill_req = 1; fill_set = 3;
      #1 chk("R12", "fill_yields", int'(fill_grant), 0);
      step(); idle();
      // R10: rollback removes only speculative lines
      fp_mismatch = 1; fp_match = 1; step(); idle();
      for (int i = 0; i < SETS; i++) step();
      read_line(1, 1, "R10", 0, 0, 0);
      read_line(1, 3, "R10", 1, 1, 0);
      // R6: speculative fill carries the bit
      fill_req = 1; fill_set = 1; fill_spec_in = 1; step(); idle();
      read_line(1, 1, "R6", 1, 1, 1);

      // random phase
      for (int n = 0; n < 5000; n++) begin
         int r;
         idle();
         r = int'($urandom % 100);
         wr_req = (r < 35);
         wr_set = SB'($urandom); wr_way = WB'($urandom);
         fill_req = (int'($urandom % 100) < 40);
         fill_set = SB'($urandom % 4);
         fill_spec_in = $urandom % 2;
         r = int'($urandom % 100);
         fp_match = (r < 2);
         fp_mismatch = (r >= 2 && r < 4);
         rd_set = SB'($urandom); rd_way = WB'($urandom);
         step();
      end
      idle();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule